// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Datapath

This block is the 32-bit datapath of a small load/store processor that spends several clock steps on each instruction. One ALU handles the program-counter increment, the branch target and the data operations. One memory port carries both instruction fetches and data accesses. Values that must survive from one step to the next sit in internal holding registers: instruction, memory data, two operands and the ALU result.

An external sequencer drives every enable and select on each step. The datapath returns the opcode and function fields, the zero flag and the overflow flag so that the sequencer can choose its next step. The datapath also holds a 32-entry register file, the program counter, and two exception registers: one captures the return address and one records the cause code. The sequencer itself and the memory array are not part of this block.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, and on its release, pc_o, epc_o, cause_o, opcode, funct, mem_addr (with addr_sel=0) and mem_wdata all read zero.
- R2: The first ALU operand is the program counter when srca_sel=0 and the operand-A holding register when srca_sel=1.
- R3: The second ALU operand is selected by srcb_sel: 0 gives the operand-B register, 1 gives the constant 4, 2 gives the sign-extended instruction bits 15:0, and 3 gives that sign-extended value shifted left by two.
- R4: alu_op selects the operation: 3'b010 add, 3'b110 subtract, 3'b000 bitwise AND, 3'b001 bitwise OR, 3'b111 signed set-less-than (result 1 or 0). zero is 1 exactly when the live ALU result is all zeros.
- R5: ovf reports signed two's-complement overflow of add and subtract, and is 0 for every other operation.
- R6: On a program-counter load, pc_src selects the new value: 0 the live ALU result, 1 the registered ALU result, 2 the jump target, 3 the fixed handler address 0x80000180.
- R7: The jump target is the top four bits of the current PC followed by instruction bits 25:0 and two zero bits.
- R8: The PC loads at a clock edge when pc_wr is 1, or when pc_wr_cond is 1 and zero is 1. Otherwise it holds.
- R9: mem_addr is the PC when addr_sel=0 and the registered ALU result when addr_sel=1. mem_wdata is the operand-B register. mem_re and mem_we follow mem_rd and mem_wr.
- R10: The register file reads at instruction bits 25:21 and 20:16. When reg_wr is 1 it writes at bits 20:16 (dst_sel=0) or bits 15:11 (dst_sel=1). The write data is the registered ALU result (wb_sel=0) or the memory data register (wb_sel=1).
- R11: Register 0 always reads as zero, even after a write to it.
- R12: The instruction register loads mem_rdata only when ir_wr is 1. opcode is its bits 31:26 and funct is its bits 5:0.
- R13: epc_o loads the live ALU result when epc_wr is 1. When cause_wr is 1, cause_o loads 0 (cause_sel=0, undefined instruction) or 1 (cause_sel=1, arithmetic overflow).
- R14: The memory data, operand-A, operand-B and ALU-result registers load on every clock edge, each one cycle after its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_wr | input | 1 | Instruction register load enable |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load qualified by zero |
| reg_wr | input | 1 | Register file write enable |
| epc_wr | input | 1 | Return-address register load |
| cause_wr | input | 1 | Cause register load |
| cause_sel | input | 1 | Cause code: 0 undefined instruction, 1 overflow |
| addr_sel | input | 1 | Memory address: 0 PC, 1 registered ALU result |
| dst_sel | input | 1 | Write register: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| srca_sel | input | 1 | First ALU operand select |
| srcb_sel | input | 2 | Second ALU operand select |
| pc_src | input | 2 | PC next-value select |
| alu_op | input | 3 | ALU operation code |
| mem_rd | input | 1 | Read strobe from sequencer |
| mem_wr | input | 1 | Write strobe from sequencer |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | Live ALU result is zero |
| ovf | output | 1 | Live signed overflow |
| pc_o | output | 32 | Program counter |
| epc_o | output | 32 | Exception return address |
| cause_o | output | 32 | Exception cause code |

## Verification
zero and ovf are combinational and settle in the same cycle that the operands and alu_op are applied. opcode, funct, pc_o, epc_o and cause_o change one edge after their enable. A new instruction reaches the operand registers two edges after ir_wr, and an ALU result becomes visible on mem_addr one edge after the operation is applied. The bench drives every input just after a rising edge and samples a few nanoseconds later. It counts these edges explicitly in each task: the flags are read before the edge, and each registered value is read after the edge that loads it.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG    = 2'd0,
        SRCB_FOUR   = 2'd1,
        SRCB_IMM    = 2'd2,
        SRCB_IMM_X4 = 2'd3
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'd0,
        PCS_ALUOUT = 2'd1,
        PCS_JUMP   = 2'd2,
        PCS_TRAP   = 2'd3
    } pc_src_e;

    localparam logic [XLEN-1:0] CAUSE_UNDEF = 32'd0;
    localparam logic [XLEN-1:0] CAUSE_OVF   = 32'd1;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam bit WRITABLE = (g != 0);
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (WRITABLE && we && (wa == AW'(g)))
                regs[g] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_dp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         is_zero,
    output logic         sgn_ovf
);
    always_comb begin
        y       = '0;
        sgn_ovf = 1'b0;
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: begin
                y       = a + b;
                sgn_ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            end
            ALU_SUB: begin
                y       = a - b;
                sgn_ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            end
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign is_zero = (y == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_dp_pkg::*;
#(
    parameter int              NREG       = 32,
    parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_0000,
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_wr,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    input  logic        reg_wr,
    input  logic        epc_wr,
    input  logic        cause_wr,
    input  logic        cause_sel,
    input  logic        addr_sel,
    input  logic        dst_sel,
    input  logic        wb_sel,
    input  logic        srca_sel,
    input  logic [1:0]  srcb_sel,
    input  logic [1:0]  pc_src,
    input  logic [2:0]  alu_op,
    input  logic        mem_rd,
    input  logic        mem_wr,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_re,
    output logic        mem_we,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        zero,
    output logic        ovf,
    output logic [31:0] pc_o,
    output logic [31:0] epc_o,
    output logic [31:0] cause_o
);
    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q, epc_q, cause_q;
    logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [AW-1:0]   rf_wa;
    logic [XLEN-1:0] opnd_a, opnd_b, alu_y, imm_sx, jump_tgt, pc_next;
    logic            alu_z, alu_v, pc_load;

    // Instruction field decode
    assign imm_sx   = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign jump_tgt = {pc_q[31:28], ir_q[25:0], 2'b00};
    assign rf_wa    = dst_sel ? AW'(ir_q[15:11]) : AW'(ir_q[20:16]);
    assign rf_wd    = wb_sel ? mdr_q : aluout_q;

    mc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk (clk),
        .rst_n (rst_n),
        .ra1 (AW'(ir_q[25:21])),
        .ra2 (AW'(ir_q[20:16])),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we (reg_wr),
        .wa (rf_wa),
        .wd (rf_wd)
    );

    // Operand selection
    assign opnd_a = srca_sel ? a_q : pc_q;

    always_comb begin
        unique case (srcb_e'(srcb_sel))
            SRCB_REG:    opnd_b = b_q;
            SRCB_FOUR:   opnd_b = 32'd4;
            SRCB_IMM:    opnd_b = imm_sx;
            SRCB_IMM_X4: opnd_b = {imm_sx[XLEN-3:0], 2'b00};
            default:     opnd_b = b_q;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .op (alu_op_e'(alu_op)),
        .a (opnd_a),
        .b (opnd_b),
        .y (alu_y),
        .is_zero (alu_z),
        .sgn_ovf (alu_v)
    );

    // Next program counter
    always_comb begin
        unique case (pc_src_e'(pc_src))
            PCS_ALU:    pc_next = alu_y;
            PCS_ALUOUT: pc_next = aluout_q;
            PCS_JUMP:   pc_next = jump_tgt;
            PCS_TRAP:   pc_next = HANDLER_PC;
            default:    pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_wr | (pc_wr_cond & alu_z);

    // Architectural and holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            epc_q    <= '0;
            cause_q  <= CAUSE_UNDEF;
        end else begin
            mdr_q    <= mem_rdata;
            a_q      <= rf_rd1;
            b_q      <= rf_rd2;
            aluout_q <= alu_y;
            if (ir_wr)    ir_q    <= mem_rdata;
            if (pc_load)  pc_q    <= pc_next;
            if (epc_wr)   epc_q   <= alu_y;
            if (cause_wr) cause_q <= cause_sel ? CAUSE_OVF : CAUSE_UNDEF;
        end
    end

    // Outputs
    assign mem_addr  = addr_sel ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_re    = mem_rd;
    assign mem_we    = mem_wr;
    assign opcode    = ir_q[31:26];
    assign funct     = ir_q[5:0];
    assign zero      = alu_z;
    assign ovf       = alu_v;
    assign pc_o      = pc_q;
    assign epc_o     = epc_q;
    assign cause_o   = cause_q;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ir_wr,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic        epc_wr,
    input logic        cause_wr,
    input logic        cause_sel,
    input logic        addr_sel,
    input logic [1:0]  pc_src,
    input logic [2:0]  alu_op,
    input logic [31:0] mem_addr,
    input logic [5:0]  opcode,
    input logic [5:0]  funct,
    input logic        zero,
    input logic        ovf,
    input logic [31:0] pc_o,
    input logic [31:0] epc_o,
    input logic [31:0] cause_o
);
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_wr || (pc_wr_cond && zero)) |=> $stable(pc_o));

    p_trap_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'd3) |=> (pc_o == 32'h8000_0180));

    p_jump_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'd2) |=> (pc_o[31:28] == $past(pc_o[31:28]) && pc_o[1:0] == 2'b00));

    p_ir_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> ($stable(opcode) && $stable(funct)));

    p_epc_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !epc_wr |=> $stable(epc_o));

    p_cause_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> (cause_o == {31'd0, $past(cause_sel)}));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (alu_op == 3'b010 || alu_op == 3'b110));

    p_fetch_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_sel |-> (mem_addr == pc_o));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .ir_wr (ir_wr),
    .pc_wr (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .epc_wr (epc_wr),
    .cause_wr (cause_wr),
    .cause_sel (cause_sel),
    .addr_sel (addr_sel),
    .pc_src (pc_src),
    .alu_op (alu_op),
    .mem_addr (mem_addr),
    .opcode (opcode),
    .funct (funct),
    .zero (zero),
    .ovf (ovf),
    .pc_o (pc_o),
    .epc_o (epc_o),
    .cause_o (cause_o)
);

// File: tb/test_mc_datapath.sv
module test_mc_datapath;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ir_wr, pc_wr, pc_wr_cond, reg_wr, epc_wr, cause_wr, cause_sel;
    logic        addr_sel, dst_sel, wb_sel, srca_sel, mem_rd, mem_wr;
    logic [1:0]  srcb_sel, pc_src;
    logic [2:0]  alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, pc_o, epc_o, cause_o;
    logic        mem_re, mem_we, zero, ovf;
    logic [5:0]  opcode, funct;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    mc_datapath i_mc_datapath (
        .clk (clk), .rst_n (rst_n),
        .ir_wr (ir_wr), .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond),
        .reg_wr (reg_wr), .epc_wr (epc_wr), .cause_wr (cause_wr),
        .cause_sel (cause_sel), .addr_sel (addr_sel), .dst_sel (dst_sel),
        .wb_sel (wb_sel), .srca_sel (srca_sel), .srcb_sel (srcb_sel),
        .pc_src (pc_src), .alu_op (alu_op), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .mem_rdata (mem_rdata), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_re (mem_re), .mem_we (mem_we), .opcode (opcode), .funct (funct),
        .zero (zero), .ovf (ovf), .pc_o (pc_o), .epc_o (epc_o), .cause_o (cause_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        z;
        logic        v;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{3'b010, 32'd5,          32'd7,          32'd12,         1'b0, 1'b0},
        '{3'b010, 32'h7FFF_FFFF,  32'd1,          32'h8000_0000,  1'b0, 1'b1},
        '{3'b010, 32'hFFFF_FFFF,  32'd1,          32'h0000_0000,  1'b1, 1'b0},
        '{3'b110, 32'd5,          32'd5,          32'h0000_0000,  1'b1, 1'b0},
        '{3'b110, 32'h8000_0000,  32'd1,          32'h7FFF_FFFF,  1'b0, 1'b1},
        '{3'b000, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'h00F0_00F0,  1'b0, 1'b0},
        '{3'b001, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'hFFF0_FFF0,  1'b0, 1'b0},
        '{3'b111, 32'hFFFF_FFFF,  32'd1,          32'd1,          1'b0, 1'b0},
        '{3'b111, 32'd1,          32'hFFFF_FFFF,  32'd0,          1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        ir_wr = 0; pc_wr = 0; pc_wr_cond = 0; reg_wr = 0; epc_wr = 0;
        cause_wr = 0; cause_sel = 0; addr_sel = 0; dst_sel = 0; wb_sel = 0;
        srca_sel = 0; srcb_sel = 2'd0; pc_src = 2'd0; alu_op = 3'b010;
        mem_rd = 0; mem_wr = 0;
    endtask

    // Load IR, then one more edge so A and B hold the addressed registers.
    task automatic load_ir(input logic [31:0] w);
        idle();
        mem_rdata = w; ir_wr = 1; tick();
        ir_wr = 0; tick();
    endtask

    // Write a register through the memory-data path (rt field, wb_sel=1).
    task automatic write_reg(input logic [4:0] idx, input logic [31:0] val);
        idle();
        mem_rdata = {6'h00, 5'd0, idx, 16'h0000}; ir_wr = 1; tick();
        ir_wr = 0; mem_rdata = val; tick();
        reg_wr = 1; wb_sel = 1; dst_sel = 0; tick();
        idle();
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        idle();
        mem_rdata = 32'hFFFF_FFFF;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 pc", pc_o, 32'h0);
        chk("R1 epc", epc_o, 32'h0);
        chk("R1 cause", cause_o, 32'h0);
        chk("R1 opcode", {26'd0, opcode}, 32'h0);
        chk("R1 addr", mem_addr, 32'h0);
        chk("R1 wdata", mem_wdata, 32'h0);
        rst_n = 1;
        mem_rdata = 32'h0;

        // R2 R3 R6: PC + 4 through the live ALU result
        srca_sel = 0; srcb_sel = 2'd1; alu_op = 3'b010; pc_src = 2'd0; pc_wr = 1;
        tick();
        idle();
        chk("R6 pc+4", pc_o, 32'd4);
        chk("R9 fetch addr", mem_addr, 32'd4);
        mem_rd = 1; mem_wr = 1; #1;
        chk("R9 strobes", {30'd0, mem_re, mem_we}, 32'd3);
        idle();

        // Vector table: R4 results and zero, R5 overflow, R14 ALUOut latency
        for (int i = 0; i < NVEC; i++) begin
            write_reg(5'd1, VECS[i].a);
            write_reg(5'd2, VECS[i].b);
            load_ir({6'h00, 5'd1, 5'd2, 5'd3, 11'd0});
            srca_sel = 1; srcb_sel = 2'd0; alu_op = VECS[i].op;
            #1;
            chk("R4 zero", {31'd0, zero}, {31'd0, VECS[i].z});
            chk("R5 ovf", {31'd0, ovf}, {31'd0, VECS[i].v});
            tick();
            addr_sel = 1; #1;
            chk("R4 R14 result", mem_addr, VECS[i].r);
            idle();
        end
        chk("R6 pc after vectors", pc_o, 32'd4);

        // R3 R8: branch taken (target = PC + imm*4, equal operands)
        write_reg(5'd1, 32'h55);
        write_reg(5'd2, 32'h55);
        load_ir({6'h04, 5'd1, 5'd2, 16'h0003});
        srca_sel = 0; srcb_sel = 2'd3; alu_op = 3'b010; tick();
        srca_sel = 1; srcb_sel = 2'd0; alu_op = 3'b110; pc_src = 2'd1; pc_wr_cond = 1;
        #1;
        chk("R8 zero on equal", {31'd0, zero}, 32'd1);
        tick();
        idle();
        chk("R8 branch taken", pc_o, 32'd16);

        // R8: branch not taken
        write_reg(5'd2, 32'h56);
        load_ir({6'h04, 5'd1, 5'd2, 16'h0003});
        srca_sel = 0; srcb_sel = 2'd3; alu_op = 3'b010; tick();
        srca_sel = 1; srcb_sel = 2'd0; alu_op = 3'b110; pc_src = 2'd1; pc_wr_cond = 1;
        tick();
        idle();
        chk("R8 branch not taken", pc_o, 32'd16);

        // R3: negative sign-extended immediate, PC + (-8)
        load_ir({6'h23, 5'd1, 5'd2, 16'hFFF8});
        srca_sel = 0; srcb_sel = 2'd2; alu_op = 3'b010; tick();
        addr_sel = 1; #1;
        chk("R3 R9 sext imm", mem_addr, 32'd8);
        idle();

        // R6: handler address
        pc_src = 2'd3; pc_wr = 1; tick();
        idle();
        chk("R6 handler", pc_o, 32'h8000_0180);

        // R7 R12: jump keeps PC[31:28]
        load_ir({6'h02, 26'h3AB_CDEF});
        chk("R12 opcode", {26'd0, opcode}, 32'h02);
        chk("R12 funct", {26'd0, funct}, 32'h2F);
        pc_src = 2'd2; pc_wr = 1; tick();
        idle();
        chk("R7 jump", pc_o, 32'h8EAF_37BC);

        // R12: IR holds without ir_wr
        mem_rdata = 32'hFFFF_FFFF; tick();
        chk("R12 hold", {26'd0, opcode}, 32'h02);

        // R13: EPC = PC - 4, cause codes
        srca_sel = 0; srcb_sel = 2'd1; alu_op = 3'b110; epc_wr = 1; tick();
        idle();
        chk("R13 epc", epc_o, 32'h8EAF_37B8);
        cause_wr = 1; cause_sel = 1; tick();
        chk("R13 cause ovf", cause_o, 32'd1);
        cause_sel = 0; tick();
        idle();
        chk("R13 cause undef", cause_o, 32'd0);

        // R11: register 0 ignores writes
        write_reg(5'd0, 32'hDEAD_BEEF);
        load_ir({6'h00, 5'd0, 5'd0, 5'd0, 11'd0});
        chk("R11 reg0", mem_wdata, 32'h0);

        // R10: write to rd from the ALU result register, read back on B
        load_ir({6'h00, 5'd0, 5'd0, 5'd7, 11'd0});
        srca_sel = 0; srcb_sel = 2'd1; alu_op = 3'b010; tick();
        reg_wr = 1; dst_sel = 1; wb_sel = 0; tick();
        idle();
        load_ir({6'h00, 5'd0, 5'd7, 5'd0, 11'd0});
        chk("R10 rd write", mem_wdata, 32'h8EAF_37C0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule